// File: doc/BRIEF.md
# HDLC Frame Receiver with Service-Point Address Filter

This block recovers HDLC frames from a single serial line. Each bit arrives on `bit_in` and counts only in a cycle where `bit_en` is high. The receiver finds the flag octets that open and close a frame and removes the zeros the transmitter stuffed after runs of five ones. It packs the remaining bits into bytes, least significant bit first, and checks the 16-bit frame check sequence. Each frame is accepted or rejected on its first address byte.

Accepted payload bytes leave on a byte-wide interface as one-cycle `out_valid` beats. The final payload byte carries `out_last` and a CRC verdict on `out_crc_ok`. The two check bytes are never forwarded. Three status outputs tell the host about line conditions: a one-cycle CRC error pulse, a one-cycle abort pulse and a level idle indication. A downstream buffer is expected to hold the beats of a frame until the last one, and to drop them when an abort pulse arrives.

Top module: `hdlc_rx_sapi`

## Requirements
- R1: A flag is the bit sequence 0,1,1,1,1,1,1,0 (0x7E). Bytes received between an opening and a closing flag are output in arrival order on `out_data` with `out_valid` high for one cycle each. Bit 0 of each byte is the first bit received. `out_last` is high only on the final payload byte.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed and does not count as a data bit.
- R3: The CRC register is preset to 0xFFFF and runs the polynomial x^16+x^12+x^5+1 LSB first (reflected constant 0x8408) over the payload and the check bytes. The transmitter sends the complemented CRC, low byte first. When the final remainder equals 0xF0B8 and the bit count is a whole number of bytes, `out_crc_ok` is high on the last beat. Otherwise `out_crc_ok` is low and `stat_crc_err` pulses for one cycle together with that beat.
- R4: The two check bytes are not output, so an accepted frame of N payload bytes yields exactly N beats.
- R5: The service-point field is bits 7..2 of the first byte. A frame is accepted only when that field equals 0, 16 or 63. A rejected frame produces no beats and no CRC error pulse.
- R6: A frame with fewer than three bytes between its flags produces no beats and no status pulse.
- R7: Seven consecutive 1s inside a frame that has delivered at least one data bit abort it. `stat_abort` pulses once, no `out_last` beat is produced for that frame, and the line is ignored until the next flag.
- R8: A run of seven or more 1s after a closing flag, before any frame content, produces no abort pulse, and a longer run does not pulse again.
- R9: `stat_idle` goes high once fifteen consecutive 1s have been received. It stays high while 1s continue, and it goes low after the next received 0. After fourteen 1s it is still low.
- R10: A closing flag also opens the next frame. Back-to-back flags produce no output.
- R11: During and right after reset, `out_valid`, `out_last`, `stat_crc_err`, `stat_abort` and `stat_idle` are low.
- R12: While `bit_en` is low, `bit_in` is ignored. Beats appear only in the cycle after an enabled bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | One-cycle beat strobe |
| out_last | output | 1 | Beat is the last payload byte of the frame |
| out_crc_ok | output | 1 | CRC verdict, meaningful with `out_last` |
| stat_crc_err | output | 1 | One-cycle pulse on a bad frame check |
| stat_abort | output | 1 | One-cycle pulse when a frame is aborted |
| stat_idle | output | 1 | Level: fifteen or more consecutive ones |

## Verification
The hardest situation to reach from the ports is a run of ones near a frame boundary. Seven ones must abort a frame that has content, but not the gap after a closing flag, and stuffed zeros next to a flag must not shift the byte alignment. The bench contains a transmitter model that inserts stuffing and computes the check bytes, and it drives runs of ones bit by bit. It sends payloads full of 0xFF so that stuffed zeros land next to check bytes and flags, and it aborts a frame in mid-byte before letting the line drift into idle. After each frame the bench checks that a good frame is received intact.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants and types for the HDLC receiver.
// Assumes LSB-first bit order on the line and a 16-bit reflected CRC.
package hdlc_rx_pkg;
    localparam int STUFF_RUN = 5;   // ones before a stuffed zero
    localparam int FLAG_RUN  = 6;   // ones inside a flag
    localparam int IDLE_RUN  = 15;  // ones that mean an idle line

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_LS = 16'h8408;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

    // Per-bit events decoded from the raw line
    typedef struct packed {
        logic bit_vld;    // a destuffed data bit is present
        logic bit_val;    // its value
        logic flag;       // closing zero of a flag seen
        logic abort_run;  // seventh consecutive one seen
    } line_ev_t;
endpackage

// File: rtl/hdlc_line_decoder.sv
// Line decoder: counts consecutive ones on the enabled line bits and turns
// each enabled bit into a data bit, a dropped stuff zero, a flag or an
// abort event. Also reports a level idle indication.
// Assumes RUN_W is wide enough to hold the idle run length.
module hdlc_line_decoder
    import hdlc_rx_pkg::*;
#(
    parameter int RUN_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en,
    input  logic     bit_in,
    output line_ev_t ev,
    output logic     idle
);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_RUN);
    localparam logic [RUN_W-1:0] STUFF_L = RUN_W'(STUFF_RUN);
    localparam logic [RUN_W-1:0] FLAG_L  = RUN_W'(FLAG_RUN);

    logic [RUN_W-1:0] run_q;

    // Track the run of consecutive ones, saturating at the idle length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_en) begin
            if (bit_in) begin
                if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    // Classify the current enabled bit against the run before it
    always_comb begin
        ev = '0;
        if (bit_en) begin
            if (bit_in) begin
                ev.bit_vld   = (run_q < STUFF_L);
                ev.bit_val   = 1'b1;
                ev.abort_run = (run_q == FLAG_L);
            end else if (run_q < STUFF_L) begin
                ev.bit_vld = 1'b1;
                ev.bit_val = 1'b0;
            end else if (run_q == FLAG_L) begin
                ev.flag = 1'b1;
            end
        end
    end

    assign idle = (run_q == RUN_MAX);

    // R9: a received zero always ends the idle indication
    assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bit_in) |=> !idle);
    // R9: idle can only appear after an enabled one
    assert_idle_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(bit_en && bit_in));
endmodule

// File: rtl/hdlc_bit_delay.sv
// Holds back the newest DEPTH destuffed bits. The opening part of a flag
// enters as data bits before the flag is recognised, and the flush drops
// those bits. A bit leaves only when DEPTH newer bits follow it.
// Assumes flush and in_vld are never high together.
module hdlc_bit_delay #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic in_vld,
    input  logic in_bit,
    output logic out_vld,
    output logic out_bit
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DEPTH-1:0] sr_q;
    logic [CNT_W-1:0] fill_q;

    // Shift in data bits and count how many valid bits are held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (flush) begin
            fill_q <= '0;
        end else if (in_vld) begin
            sr_q <= {sr_q[DEPTH-2:0], in_bit};
            if (fill_q != FULL) fill_q <= fill_q + 1'b1;
        end
    end

    assign out_vld = in_vld && (fill_q == FULL);
    assign out_bit = sr_q[DEPTH-1];
endmodule

// File: rtl/hdlc_crc16.sv
// Serial CRC-16 (x^16+x^12+x^5+1), LSB first, preset to all ones.
// Reports whether the remainder equals the good-frame residue.
// Assumes init and bit_vld are never high together.
module hdlc_crc16
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic bit_vld,
    input  logic bit_val,
    output logic good
);
    logic [15:0] crc_q;

    // Preset on a frame boundary, otherwise fold in one data bit
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc_q <= CRC_PRESET;
        end else if (bit_vld) begin
            crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ bit_val) ? CRC_POLY_LS : 16'h0000);
        end
    end

    assign good = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/hdlc_byte_pack.sv
// Packs data bits into bytes, first bit into bit 0. byte_done is high in
// the cycle the final bit of a byte arrives, with byte_val complete.
// partial reports bits held that do not yet form a whole byte.
module hdlc_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_vld,
    input  logic              bit_val,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              partial
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Shift bits in from the top and count bit positions
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            if (!rst_n) sh_q <= '0;
        end else if (bit_vld) begin
            sh_q  <= byte_val;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign byte_val  = {bit_val, sh_q[BYTE_W-1:1]};
    assign byte_done = bit_vld && (cnt_q == LAST);
    assign partial   = (cnt_q != '0);
endmodule

// File: rtl/hdlc_rx_sapi.sv
// HDLC frame receiver top. It ties the line decoder, the flag-tail delay,
// the byte packer and the CRC together. It filters each frame on the
// service-point field of its first byte. Payload leaves FCS_BYTES behind
// the line, so the check bytes are never forwarded. The last payload byte
// is released at the closing flag with the CRC verdict.
// Assumes MIN_BYTES > FCS_BYTES and one bit per enabled cycle at most.
module hdlc_rx_sapi
    import hdlc_rx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int SAPI_W    = 6,
    parameter int NUM_SAPI  = 3,
    parameter logic [NUM_SAPI*SAPI_W-1:0] SAPI_LIST = {6'd63, 6'd16, 6'd0},
    parameter bit FILTER_EN = 1'b1,
    parameter int MIN_BYTES = 3,
    parameter int FCS_BYTES = 2,
    parameter int RUN_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    output logic              out_crc_ok,
    output logic              stat_crc_err,
    output logic              stat_abort,
    output logic              stat_idle
);
    localparam int CNT_W = $clog2(MIN_BYTES + FCS_BYTES + 2);
    localparam logic [CNT_W-1:0] MIN_L  = CNT_W'(MIN_BYTES);
    localparam logic [CNT_W-1:0] EMIT_L = CNT_W'(FCS_BYTES + 1);
    localparam logic [CNT_W-1:0] SAT_L  = '1;

    line_ev_t          ev;
    logic              dl_vld, dl_bit, boundary;
    logic              pk_done, pk_partial, crc_good, addr_ok;
    logic [BYTE_W-1:0] pk_byte;
    logic [NUM_SAPI-1:0] sapi_hit;

    logic              in_frame_q, accept_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] hold_q [FCS_BYTES+1];

    assign boundary = ev.flag || ev.abort_run;

    hdlc_line_decoder #(.RUN_W(RUN_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .ev(ev), .idle(stat_idle)
    );

    hdlc_bit_delay #(.DEPTH(FLAG_RUN)) u_dly (
        .clk(clk), .rst_n(rst_n), .flush(boundary),
        .in_vld(ev.bit_vld && in_frame_q), .in_bit(ev.bit_val),
        .out_vld(dl_vld), .out_bit(dl_bit)
    );

    hdlc_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(boundary),
        .bit_vld(dl_vld), .bit_val(dl_bit),
        .byte_done(pk_done), .byte_val(pk_byte), .partial(pk_partial)
    );

    hdlc_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .init(boundary),
        .bit_vld(dl_vld), .bit_val(dl_bit), .good(crc_good)
    );

    // One comparator per fixed service-point value
    for (genvar g = 0; g < NUM_SAPI; g++) begin : g_sapi
        assign sapi_hit[g] =
            (pk_byte[BYTE_W-1 -: SAPI_W] == SAPI_LIST[g*SAPI_W +: SAPI_W]);
    end

    if (FILTER_EN) begin : g_filter
        assign addr_ok = |sapi_hit;
    end else begin : g_nofilter
        assign addr_ok = 1'b1;
    end

    // Frame sequencing: boundaries, address decision, delayed byte release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q   <= 1'b0;
            accept_q     <= 1'b0;
            cnt_q        <= '0;
            out_data     <= '0;
            out_valid    <= 1'b0;
            out_last     <= 1'b0;
            out_crc_ok   <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_abort   <= 1'b0;
            for (int i = 0; i <= FCS_BYTES; i++) hold_q[i] <= '0;
        end else begin
            out_valid    <= 1'b0;
            out_last     <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_abort   <= 1'b0;
            if (ev.flag) begin
                in_frame_q <= 1'b1;
                cnt_q      <= '0;
                if (in_frame_q && cnt_q >= MIN_L && accept_q) begin
                    out_valid    <= 1'b1;
                    out_last     <= 1'b1;
                    out_data     <= hold_q[FCS_BYTES];
                    out_crc_ok   <= crc_good && !pk_partial;
                    stat_crc_err <= !(crc_good && !pk_partial);
                end
            end else if (ev.abort_run) begin
                if (in_frame_q && (cnt_q != '0 || pk_partial)) stat_abort <= 1'b1;
                in_frame_q <= 1'b0;
                cnt_q      <= '0;
            end else if (pk_done) begin
                for (int i = FCS_BYTES; i > 0; i--) hold_q[i] <= hold_q[i-1];
                hold_q[0] <= pk_byte;
                if (cnt_q != SAT_L) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '0) accept_q <= addr_ok;
                if (cnt_q >= EMIT_L && accept_q) begin
                    out_valid <= 1'b1;
                    out_data  <= hold_q[FCS_BYTES];
                end
            end
        end
    end

    // R1: last is only ever tagged on a beat
    assert_last_has_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R3: a CRC error pulse marks a failing last beat
    assert_crc_err_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_crc_err |-> (out_valid && out_last && !out_crc_ok));
    // R7: an aborted frame never gets a last beat
    assert_abort_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_abort |-> !out_last);
    // R6: a flag that closes a short frame releases nothing
    assert_short_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.flag && in_frame_q && cnt_q < MIN_L) |=> !out_valid);
    // R12: beats only follow an enabled line bit
    assert_beat_after_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bit_en));
endmodule

// File: tb/hdlc_rx_sapi_test.sv
`timescale 1ns/1ps
module hdlc_rx_sapi_test;
    logic       clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
    logic [7:0] out_data;
    logic       out_valid, out_last, out_crc_ok, stat_crc_err, stat_abort, stat_idle;

    always #4 clk = ~clk;  // 125 MHz

    hdlc_rx_sapi uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_crc_ok(out_crc_ok), .stat_crc_err(stat_crc_err),
        .stat_abort(stat_abort), .stat_idle(stat_idle)
    );

    int checks = 0, errors = 0, tx_ones = 0, rx_n = 0, n_abort = 0, n_crcerr = 0;
    bit done = 1'b0;
    logic [7:0] rx_data [64];
    bit         rx_last [64];
    bit         rx_ok   [64];
    logic [7:0] fb [64];

    // len[23:16] sapi[15:10] bad_fcs[9] rsvd[8] seed[7:0]
    localparam logic [23:0] VEC [7] = '{
        {8'd6,  6'd0,  1'b0, 1'b0, 8'h5A},
        {8'd1,  6'd16, 1'b0, 1'b0, 8'h00},
        {8'd10, 6'd63, 1'b0, 1'b0, 8'hFF},
        {8'd5,  6'd16, 1'b1, 1'b0, 8'h33},
        {8'd4,  6'd5,  1'b0, 1'b0, 8'h81},
        {8'd8,  6'd0,  1'b0, 1'b0, 8'hF0},
        {8'd3,  6'd62, 1'b1, 1'b0, 8'h11}
    };

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (rx_n < 64) begin
                    rx_data[rx_n] = out_data;
                    rx_last[rx_n] = out_last;
                    rx_ok[rx_n]   = out_crc_ok;
                end
                rx_n++;
            end
            if (stat_abort)   n_abort++;
            if (stat_crc_err) n_crcerr++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One enabled line bit; garbage on bit_in while disabled (R12)
    task automatic send_raw(bit b);
        @(negedge clk); bit_in = b; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0; bit_in = ~b;
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(bit b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
        end else tx_ones = 0;
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] d);
        for (int i = 0; i < 8; i++)
            c = (c >> 1) ^ ((c[0] ^ d[i]) ? 16'h8408 : 16'h0000);
        return c;
    endfunction

    // Payload from fb, then check bytes, then closing flag
    task automatic send_frame(int n, bit corrupt);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            send_byte(fb[i]);
            c = crc_byte(c, fb[i]);
        end
        c = ~c;
        if (corrupt) c = c ^ 16'h0001;
        send_byte(c[7:0]);
        send_byte(c[15:8]);
        send_flag();
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: outputs quiet during reset
        chk("R11 valid in reset", int'(out_valid), 0);
        chk("R11 idle in reset",  int'(stat_idle), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid after reset", int'(out_valid), 0);
        chk("R11 abort after reset", int'(stat_abort), 0);
        chk("R11 last after reset",  int'(out_last), 0);

        // Vector table: frames sharing flags (closing flag opens next)
        send_flag();
        foreach (VEC[k]) begin
            automatic int  n    = int'(VEC[k][23:16]);
            automatic logic [5:0] sp = VEC[k][15:10];
            automatic bit  bad  = VEC[k][9];
            automatic logic [7:0] seed = VEC[k][7:0];
            automatic bit  acc  = (sp == 6'd0) || (sp == 6'd16) || (sp == 6'd63);
            fb[0] = {sp, 2'b00};
            for (int i = 1; i < n; i++)
                fb[i] = (i % 3 == 1) ? 8'hFF : (seed ^ 8'(i * 37));
            rx_n = 0; n_crcerr = 0;
            send_frame(n, bad);
            settle();
            chk($sformatf("R4 R5 R10 beat count vec %0d", k), rx_n, acc ? n : 0);
            chk($sformatf("R3 R5 crc error pulses vec %0d", k), n_crcerr, (acc && bad) ? 1 : 0);
            if (acc && rx_n == n) begin
                for (int i = 0; i < n; i++) begin
                    chk($sformatf("R1 R2 R12 data vec %0d byte %0d", k, i),
                        int'(rx_data[i]), int'(fb[i]));
                    chk($sformatf("R1 last vec %0d byte %0d", k, i),
                        int'(rx_last[i]), (i == n - 1) ? 1 : 0);
                end
                chk($sformatf("R3 crc verdict vec %0d", k), int'(rx_ok[n-1]), bad ? 0 : 1);
            end
        end

        // R10: back-to-back flags give nothing
        rx_n = 0;
        repeat (3) send_flag();
        settle();
        chk("R10 back-to-back flags", rx_n, 0);

        // R6: two bytes between flags are silently dropped
        rx_n = 0; n_crcerr = 0; n_abort = 0;
        send_byte(8'h00); send_byte(8'h12);
        send_flag();
        settle();
        chk("R6 short frame beats", rx_n, 0);
        chk("R6 short frame crc pulses", n_crcerr, 0);
        chk("R6 short frame abort pulses", n_abort, 0);

        // R7: abort mid-frame, then let the line run into idle (R9, R8)
        rx_n = 0; n_abort = 0;
        send_byte(8'h40); send_byte(8'h01); send_byte(8'h22);
        send_byte(8'h33); send_byte(8'h00);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        settle();
        chk("R7 abort pulse count", n_abort, 1);
        begin
            automatic int lasts = 0;
            for (int i = 0; i < rx_n && i < 64; i++) lasts += int'(rx_last[i]);
            chk("R7 no last beat on aborted frame", lasts, 0);
        end
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        chk("R9 idle low after 14 ones", int'(stat_idle), 0);
        send_raw(1'b1);
        chk("R9 idle high after 15 ones", int'(stat_idle), 1);
        for (int i = 0; i < 5; i++) send_raw(1'b1);
        chk("R9 idle held while ones continue", int'(stat_idle), 1);
        settle();
        chk("R8 no second abort in long run", n_abort, 1);
        send_raw(1'b0);
        chk("R9 idle cleared by a zero", int'(stat_idle), 0);

        // R7: receiver resumes at the next flag
        send_flag();
        rx_n = 0; n_crcerr = 0;
        fb[0] = 8'h00; fb[1] = 8'hA5;
        send_frame(2, 1'b0);
        settle();
        chk("R7 recovered frame beats", rx_n, 2);
        chk("R7 recovered frame last", int'(rx_last[1]), 1);
        chk("R7 recovered frame crc ok", int'(rx_ok[1]), 1);

        // R8: ones right after a closing flag do not abort
        n_abort = 0;
        for (int i = 0; i < 10; i++) send_raw(1'b1);
        settle();
        chk("R8 no abort after closing flag", n_abort, 0);
        send_flag();
        settle();
        finish_up();
    end
endmodule